// File: doc/BRIEF.md
# Display Presence Probe Sequencer

This block decides whether a monitor is attached to a display data channel by asking it for the first bytes of its identification data. On a start pulse it commands a byte-level I2C master to perform two transfers to the display's fixed device address. The first transfer writes a single zero byte, which points the display's internal read pointer at the beginning of its data. The second transfer reads eight bytes back. Each returned byte is checked against the standard header signature: a zero byte, six bytes of 0xFF, and a final zero byte.

Only the leading six header bytes decide the result. The last two are not examined, because later validation stages are able to repair them. If either transfer reports an error, or the read ends with the wrong number of bytes, the display is reported absent. The result is given as one bit alongside a single-cycle done pulse. It stays on the output until the next accepted start.

The I2C bit timing, checksum checking of the full data block and any connector switching are handled by other blocks.

Top module: `ddc_probe_seq`

## Requirements
- R1: After reset, busy_o, done_o, present_o and mst_go_o are all 0.
- R2: One cycle after a start is accepted in idle, mst_go_o pulses for one cycle with mst_rd_o=0, mst_addr_o=0x50, mst_len_o=1 and mst_wdata_o=0x00.
- R3: The read command (mst_go_o with mst_rd_o=1, mst_len_o=8, mst_addr_o=0x50) is issued exactly one cycle after the master signals mst_done_i without mst_err_i for the write, and never earlier.
- R4: An mst_err_i during either transfer ends the probe with a done pulse and present_o=0 on the next cycle, and no further command is issued. If mst_err_i and mst_done_i arrive together, the error wins.
- R5: When exactly eight bytes are received and they begin 0x00, 0xFF, 0xFF, 0xFF, 0xFF, 0xFF (byte order as received), the done pulse comes with present_o=1.
- R6: The seventh and eighth received bytes have no effect on the result.
- R7: A mismatch in any of the first six received bytes gives present_o=0.
- R8: A read that completes with a received byte count other than eight gives present_o=0.
- R9: A start pulse while busy_o=1 is ignored: no extra command and no extra done pulse.
- R10: done_o is a single-cycle pulse. present_o changes only on the done cycle or when a start is accepted, where it clears to 0. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches a probe when idle |
| busy_o | output | 1 | A probe is in progress |
| done_o | output | 1 | One-cycle pulse when the probe ends |
| present_o | output | 1 | Probe result: 1 means a display was found |
| mst_go_o | output | 1 | One-cycle command strobe to the I2C master |
| mst_rd_o | output | 1 | Command direction: 1 = read, 0 = write |
| mst_addr_o | output | 7 | 7-bit device address of the command |
| mst_len_o | output | 4 | Number of data bytes in the command |
| mst_wdata_o | output | 8 | Byte to write for the write command |
| mst_done_i | input | 1 | Master reports the current transfer finished |
| mst_err_i | input | 1 | Master reports the current transfer failed |
| mst_rvld_i | input | 1 | A received byte is valid on mst_rdata_i |
| mst_rdata_i | input | 8 | Received byte |

## Verification
The embedded properties check on every cycle that the following hold: command strobes are single pulses, the read command only follows a clean write completion, any master error leads straight to an absent result, done is a pulse, and the result only moves on a done or an accepted start. Whether a given byte stream produces present or absent can only be seen in the bench scenarios. These cover the header content, the ignored trailing bytes, the short reads, the error placement and the start pulses sent while busy, each compared against values worked out from the requirements.

// File: rtl/ddc_probe_seq.sv
module ddc_probe_seq #(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         RD_LEN    = 8,
  parameter int         MIN_MATCH = 6,
  parameter int         LEN_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             present_o,
  output logic             mst_go_o,
  output logic             mst_rd_o,
  output logic [6:0]       mst_addr_o,
  output logic [LEN_W-1:0] mst_len_o,
  output logic [7:0]       mst_wdata_o,
  input  logic             mst_done_i,
  input  logic             mst_err_i,
  input  logic             mst_rvld_i,
  input  logic [7:0]       mst_rdata_i
);

  localparam int CNT_W = $clog2(RD_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RD_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_WGO, S_WWAIT, S_RGO, S_RWAIT, S_FIN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             lead_ok;
  logic             res;

  logic [7:0] exp_byte;
  assign exp_byte = (cnt == '0 || cnt == CNT_W'(RD_LEN - 1)) ? 8'h00 : 8'hFF;

  logic accept;
  assign accept = start_i && (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      lead_ok <= 1'b0;
      res     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_WGO;
          cnt     <= '0;
          lead_ok <= 1'b1;
          res     <= 1'b0;
        end
        S_WGO:  st <= S_WWAIT;
        S_WWAIT: begin
          if (mst_err_i) begin
            st  <= S_FIN;
            res <= 1'b0;
          end else if (mst_done_i) begin
            st <= S_RGO;
          end
        end
        S_RGO:  st <= S_RWAIT;
        S_RWAIT: begin
          if (mst_err_i) begin
            st  <= S_FIN;
            res <= 1'b0;
          end else if (mst_done_i) begin
            st  <= S_FIN;
            res <= lead_ok && (cnt == CNT_W'(RD_LEN));
          end else if (mst_rvld_i) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (cnt < CNT_W'(MIN_MATCH) && mst_rdata_i != exp_byte) lead_ok <= 1'b0;
          end
        end
        S_FIN:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st != S_IDLE);
  assign done_o      = (st == S_FIN);
  assign present_o   = res;
  assign mst_go_o    = (st == S_WGO) || (st == S_RGO);
  assign mst_rd_o    = (st == S_RGO) || (st == S_RWAIT);
  assign mst_addr_o  = DEV_ADDR;
  assign mst_len_o   = (st == S_RGO || st == S_RWAIT) ? LEN_W'(RD_LEN) : LEN_W'(1);
  assign mst_wdata_o = 8'h00;

  p_go_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mst_go_o |=> !mst_go_o);

  p_rd_after_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_go_o && mst_rd_o) |-> $past(mst_done_i && !mst_err_i));

  p_err_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mst_go_o && !done_o && mst_err_i) |=> (done_o && !present_o && !mst_go_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(present_o) |-> (done_o || $past(start_i && !busy_o)));

endmodule

// File: tb/ddc_probe_seq_bench.sv
`timescale 1ns/1ps
module ddc_probe_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, present_o, mst_go_o, mst_rd_o;
  logic [6:0] mst_addr_o;
  logic [3:0] mst_len_o;
  logic [7:0] mst_wdata_o;
  logic mst_done_i = 1'b0, mst_err_i = 1'b0, mst_rvld_i = 1'b0;
  logic [7:0] mst_rdata_i = 8'h00;

  int n_chk = 0, n_fail = 0;
  int go_cnt = 0, done_cnt = 0;

  always #2.5 clk = ~clk;

  ddc_probe_seq u_ddc_probe_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .present_o(present_o), .mst_go_o(mst_go_o), .mst_rd_o(mst_rd_o),
    .mst_addr_o(mst_addr_o), .mst_len_o(mst_len_o), .mst_wdata_o(mst_wdata_o),
    .mst_done_i(mst_done_i), .mst_err_i(mst_err_i), .mst_rvld_i(mst_rvld_i),
    .mst_rdata_i(mst_rdata_i));

  always @(posedge clk) begin
    if (mst_go_o) go_cnt <= go_cnt + 1;
    if (done_o) done_cnt <= done_cnt + 1;
  end

  // {bytes[63:0] first byte in MSBs, count[3:0], wr_err, rd_err, expected}
  localparam int NV = 8;
  localparam logic [70:0] VEC [NV] = '{
    {64'h00FFFFFFFFFFFF00, 4'd8, 1'b0, 1'b0, 1'b1},
    {64'h00FFFFFFFFFF1234, 4'd8, 1'b0, 1'b0, 1'b1},
    {64'h00FFFEFFFFFFFF00, 4'd8, 1'b0, 1'b0, 1'b0},
    {64'h00FFFFFFFF00FF00, 4'd8, 1'b0, 1'b0, 1'b0},
    {64'hFFFFFFFFFFFFFF00, 4'd8, 1'b0, 1'b0, 1'b0},
    {64'h00FFFFFFFFFFFF00, 4'd8, 1'b1, 1'b0, 1'b0},
    {64'h00FFFFFFFFFFFF00, 4'd8, 1'b0, 1'b1, 1'b0},
    {64'h00FFFFFFFFFFFF00, 4'd7, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (done_o) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input logic [70:0] v, input int extra_start);
    logic [63:0] b;
    logic seen;
    int g0, d0;
    b = v[70:7];
    g0 = go_cnt; d0 = done_cnt;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(mst_go_o && !mst_rd_o && mst_addr_o == 7'h50 && mst_len_o == 4'd1 && mst_wdata_o == 8'h00,
        "R2 write cmd", {mst_go_o, mst_rd_o, mst_addr_o, mst_len_o, mst_wdata_o}, {1'b1, 1'b0, 7'h50, 4'd1, 8'h00});
    chk(present_o == 1'b0, "R10 cleared at start", present_o, 0);
    if (extra_start != 0) start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(!mst_go_o, "R3 no read before write done", mst_go_o, 0);
    if (v[2]) mst_err_i = 1'b1; else mst_done_i = 1'b1;
    if (extra_start != 0) start_i = 1'b1;
    @(negedge clk); mst_err_i = 1'b0; mst_done_i = 1'b0; start_i = 1'b0;
    if (!v[2]) begin
      chk(mst_go_o && mst_rd_o && mst_len_o == 4'd8 && mst_addr_o == 7'h50, "R3 read cmd",
          {mst_go_o, mst_rd_o, mst_len_o, mst_addr_o}, {1'b1, 1'b1, 4'd8, 7'h50});
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        if (k < int'(v[6:3])) begin
          mst_rvld_i = 1'b1; mst_rdata_i = b[63-8*k -: 8];
          @(negedge clk);
        end
      end
      mst_rvld_i = 1'b0;
      if (v[1]) mst_err_i = 1'b1; else mst_done_i = 1'b1;
      @(negedge clk); mst_err_i = 1'b0; mst_done_i = 1'b0;
    end
    wait_done(seen);
    chk(seen, "R4 done seen", seen, 1);
    chk(present_o == v[0], v[2] || v[1] ? "R4 err absent" : (v[6:3] != 4'd8 ? "R8 count" : "R5/R6/R7 result"),
        present_o, v[0]);
    @(negedge clk);
    chk(!done_o, "R10 done pulse", done_o, 0);
    repeat (3) @(negedge clk);
    chk(go_cnt - g0 == (v[2] ? 1 : 2), "R4/R9 command count", go_cnt - g0, v[2] ? 1 : 2);
    chk(done_cnt - d0 == 1, "R9 one done", done_cnt - d0, 1);
    chk(present_o == v[0], "R10 held", present_o, v[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !present_o && !mst_go_o, "R1 reset state",
        {busy_o, done_o, present_o, mst_go_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !mst_go_o, "R1 idle after reset", {busy_o, mst_go_o}, 0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i], 0);
    // R9: extra starts while busy, good header
    run_vec(VEC[0], 1);
    // R4: error and done together on the write, error wins
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); mst_err_i = 1'b1; mst_done_i = 1'b1;
    @(negedge clk); mst_err_i = 1'b0; mst_done_i = 1'b0;
    chk(done_o && !present_o && !mst_go_o, "R4 err wins", {done_o, present_o, mst_go_o}, 3'b100);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule